// File: doc/BRIEF.md
# Triple Recirculating Tapped Shift Register

The block holds three independent 64-bit serial shift registers that advance together on one clock whenever a shared shift enable is high. Each register has its own serial data input and its own load select. While the select is high the first stage takes the external bit. While it is low the first stage takes the bit leaving the last stage, so the register recirculates and keeps its contents.

Each register drives two outputs. The end output is taken after stage 64. The early tap is taken after stage 60, four stages sooner, so decimal correction logic beside the block sees the next 4-bit digit one digit time before it reaches the end of the chain. A typical serial BCD datapath keeps an accumulator in one register and operands in the others. It feeds an adder's sum back into a register's input while that register's select is high, and lets the register recirculate while its select is low.

Top module: `tapped_recirc_sr`

## Requirements
- R1: The three registers are independent: the input and load select of one register never affect the stored bits or outputs of another.
- R2: While shiftEn is low at a rising clock edge, no stage of any register changes, whatever the data and select inputs are doing.
- R3: With shiftEn high and loadCtl[i] high at a rising edge, the first stage of register i takes serIn[i] and every other stage takes the value of the stage before it.
- R4: With shiftEn high and loadCtl[i] low at a rising edge, the first stage of register i takes the value that endOut[i] showed before that edge.
- R5: tapOut[i] shows stage 60 of register i, so a bit entered at one shift appears on tapOut[i] after exactly 60 shifts.
- R6: endOut[i] shows stage 64 of register i, so a bit entered at one shift appears on endOut[i] after exactly 64 shifts.
- R7: When shifts are contiguous, the value tapOut[i] shows after shift n appears on endOut[i] after shift n+4.
- R8: With the load select held low, after 64 shifts the contents of a register are back in their starting positions, so the endOut sequence repeats with a period of 64 shifts.
- R9: rstN low at a rising edge clears all 192 stages to 0 and takes priority over shifting and loading.
- R10: Both outputs come straight from register stages: a change on serIn, loadCtl or shiftEn between clock edges leaves tapOut and endOut unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Common shift clock, rising edge active |
| rstN | input | 1 | Synchronous clear, active low |
| shiftEn | input | 1 | Advances all three registers by one stage when high |
| loadCtl | input | 3 | Per register: 1 takes serIn, 0 recirculates the end bit |
| serIn | input | 3 | Per-register external serial data |
| tapOut | output | 3 | Per-register value of stage 60 |
| endOut | output | 3 | Per-register value of stage 64 |

## Verification
A wrong stored bit stays hidden at the ports until it moves to one of the two observed stages. A bad bit in stage k shows on tapOut after 60-k shifts when k is at most 60, and on endOut after 64-k shifts in every case. A bit inserted in the wrong place on entry therefore takes up to 64 shifts to show, and recirculation brings it back every 64 shifts. The bench compares both outputs of every register against a queue model on every clock, and it also runs full recirculation loops so that any corrupted position reaches a port. A slip in the tap position shows as a break in the four-shift lag between the two outputs.

// File: rtl/tapsr_pkg.sv
package tapsr_pkg;
  // strobes handed from control to every lane datapath
  typedef struct packed {
    logic shiftStb;
    logic clearStb;
  } laneStb_t;
endpackage

// File: rtl/tapsr_ctrl.sv
module tapsr_ctrl
  import tapsr_pkg::*;
(
  input  logic     rstN,
  input  logic     shiftEn,
  output laneStb_t stb
);
  // clear wins over shifting
  always_comb begin
    stb.clearStb = ~rstN;
    stb.shiftStb = shiftEn & rstN;
  end
endmodule

// File: rtl/tapsr_lane.sv
module tapsr_lane
  import tapsr_pkg::*;
#(
  parameter int LEN     = 64,
  parameter int TAP_POS = 60
) (
  input  logic     clk,
  input  laneStb_t stb,
  input  logic     selExt,
  input  logic     serIn,
  output logic     tapOut,
  output logic     endOut
);
  localparam int TAP_IDX = TAP_POS - 1;
  localparam int END_IDX = LEN - 1;

  // bit 0 is the entry stage, bit END_IDX the last
  logic [LEN-1:0] stages;
  logic           entryBit;

  always_comb entryBit = selExt ? serIn : stages[END_IDX];

  always_ff @(posedge clk) begin
    if (stb.clearStb)      stages <= '0;
    else if (stb.shiftStb) stages <= {stages[LEN-2:0], entryBit};
  end

  assign tapOut = stages[TAP_IDX];
  assign endOut = stages[END_IDX];

  AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (stb.clearStb)
    !stb.shiftStb |=> $stable(stages)); // R2
  AST_LOAD_ENTRY: assert property (@(posedge clk) disable iff (stb.clearStb)
    (stb.shiftStb && selExt) |=> (stages[0] == $past(serIn))); // R3
  AST_RECIRC_ENTRY: assert property (@(posedge clk) disable iff (stb.clearStb)
    (stb.shiftStb && !selExt) |=> (stages[0] == $past(endOut))); // R4
  AST_TAP_ADVANCE: assert property (@(posedge clk) disable iff (stb.clearStb)
    stb.shiftStb |=> (stages[TAP_IDX+1] == $past(tapOut))); // R7
endmodule

// File: rtl/tapped_recirc_sr.sv
module tapped_recirc_sr
  import tapsr_pkg::*;
#(
  parameter int NUM_CH  = 3,
  parameter int LEN     = 64,
  parameter int TAP_POS = 60
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              shiftEn,
  input  logic [NUM_CH-1:0] loadCtl,
  input  logic [NUM_CH-1:0] serIn,
  output logic [NUM_CH-1:0] tapOut,
  output logic [NUM_CH-1:0] endOut
);
  laneStb_t stb;

  tapsr_ctrl u_ctrl (
    .rstN   (rstN),
    .shiftEn(shiftEn),
    .stb    (stb)
  );

  for (genvar ch = 0; ch < NUM_CH; ch++) begin : g_lane
    tapsr_lane #(.LEN(LEN), .TAP_POS(TAP_POS)) u_lane (
      .clk   (clk),
      .stb   (stb),
      .selExt(loadCtl[ch]),
      .serIn (serIn[ch]),
      .tapOut(tapOut[ch]),
      .endOut(endOut[ch])
    );
  end
endmodule

// File: tb/tapped_recirc_sr_tb.sv
`timescale 1ns/1ps
module tapped_recirc_sr_tb;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       shiftEn = 1'b0;
  logic [2:0] loadCtl = '0;
  logic [2:0] serIn = '0;
  logic [2:0] tapOut, endOut;

  int checks = 0;
  int errors = 0;
  bit cmpOn = 1'b0;
  bit done = 1'b0;

  bit mq [3][$];
  bit endSeq [3][0:128];
  bit tapSeq [3][0:128];

  always #10 clk = ~clk;

  tapped_recirc_sr u_dut (
    .clk(clk), .rstN(rstN), .shiftEn(shiftEn), .loadCtl(loadCtl),
    .serIn(serIn), .tapOut(tapOut), .endOut(endOut)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
    end
  endtask

  function automatic bit pat(input int ch, input int i);
    case (ch)
      0:       return (i % 3) == 0;
      1:       return (i % 5) < 2;
      default: return ((i * 7 + 3) % 11) > 5;
    endcase
  endfunction

  // behavioural reference: queue per register, index 0 = newest bit
  always @(posedge clk) begin
    for (int ch = 0; ch < 3; ch++) begin
      if (!rstN) begin
        mq[ch].delete();
        for (int k = 0; k < 64; k++) mq[ch].push_back(1'b0);
      end else if (shiftEn) begin
        bit nb;
        nb = loadCtl[ch] ? serIn[ch] : mq[ch][63];
        void'(mq[ch].pop_back());
        mq[ch].push_front(nb);
      end
    end
  end

  // every-cycle comparison (R1 independence, R5 tap, R6 end)
  always @(negedge clk) begin
    if (cmpOn) begin
      for (int ch = 0; ch < 3; ch++) begin
        chk(tapOut[ch] === mq[ch][59], "R1 R5 tap vs model", int'(tapOut[ch]), int'(mq[ch][59]));
        chk(endOut[ch] === mq[ch][63], "R1 R6 end vs model", int'(endOut[ch]), int'(mq[ch][63]));
      end
    end
  end

  task automatic report();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    #(20 * 200000);
    if (!done) begin
      chk(1'b0, "watchdog", 0, 1);
      report();
    end
  end

  initial begin
    logic [2:0] holdTap, holdEnd;
    // R9: reset beats a requested load of ones
    shiftEn = 1'b1; loadCtl = 3'b111; serIn = 3'b111;
    repeat (3) @(negedge clk);
    chk(tapOut === 3'b000, "R9 tap after reset", int'(tapOut), 0);
    chk(endOut === 3'b000, "R9 end after reset", int'(endOut), 0);
    rstN = 1'b1;
    cmpOn = 1'b1;

    // R3: load 64 bits, bit i entered at shift i
    for (int i = 0; i < 64; i++) begin
      shiftEn = 1'b1; loadCtl = 3'b111;
      for (int ch = 0; ch < 3; ch++) serIn[ch] = pat(ch, i);
      @(negedge clk);
    end
    for (int ch = 0; ch < 3; ch++) begin
      chk(tapOut[ch] === pat(ch, 4), "R5 R3 tap after load", int'(tapOut[ch]), int'(pat(ch, 4)));
      chk(endOut[ch] === pat(ch, 0), "R6 R3 end after load", int'(endOut[ch]), int'(pat(ch, 0)));
    end

    // R2: hold with busy inputs
    shiftEn = 1'b0;
    holdTap = tapOut; holdEnd = endOut;
    for (int i = 0; i < 10; i++) begin
      loadCtl = 3'(i); serIn = ~3'(i);
      @(negedge clk);
      chk(tapOut === holdTap && endOut === holdEnd, "R2 hold", int'({tapOut, endOut}), int'({holdTap, holdEnd}));
    end

    // R4 R7 R8: recirculate 128 shifts, recording after each
    loadCtl = 3'b000;
    for (int k = 0; k <= 128; k++) begin
      for (int ch = 0; ch < 3; ch++) begin
        endSeq[ch][k] = endOut[ch];
        tapSeq[ch][k] = tapOut[ch];
      end
      shiftEn = (k < 128); serIn = 3'(k);
      @(negedge clk);
    end
    for (int ch = 0; ch < 3; ch++) begin
      for (int k = 0; k < 64; k++) begin
        chk(endSeq[ch][k] == pat(ch, k), "R4 recirculated order", int'(endSeq[ch][k]), int'(pat(ch, k)));
        chk(endSeq[ch][k + 64] == endSeq[ch][k], "R8 period 64", int'(endSeq[ch][k + 64]), int'(endSeq[ch][k]));
        chk(endSeq[ch][k + 4] == tapSeq[ch][k], "R7 four-shift lag", int'(endSeq[ch][k + 4]), int'(tapSeq[ch][k]));
      end
    end

    // R10: mid-cycle input changes do not reach the outputs
    shiftEn = 1'b1; loadCtl = 3'b101;
    @(posedge clk); #5;
    holdTap = tapOut; holdEnd = endOut;
    serIn = ~serIn; loadCtl = ~loadCtl; shiftEn = 1'b0;
    #2;
    chk(tapOut === holdTap && endOut === holdEnd, "R10 no combinational path", int'({tapOut, endOut}), int'({holdTap, holdEnd}));
    @(negedge clk);

    // R1: mixed per-register traffic against the model
    for (int i = 0; i < 400; i++) begin
      shiftEn = ($urandom % 4) != 0;
      loadCtl = 3'($urandom);
      serIn   = 3'($urandom);
      @(negedge clk);
    end

    // R9: clear in mid-run
    rstN = 1'b0; shiftEn = 1'b1; loadCtl = 3'b111; serIn = 3'b111;
    @(negedge clk);
    chk(tapOut === 3'b000 && endOut === 3'b000, "R9 mid-run clear", int'({tapOut, endOut}), 0);
    rstN = 1'b1;
    for (int i = 0; i < 70; i++) begin
      loadCtl = 3'b010; serIn = 3'b111;
      @(negedge clk);
    end
    chk(endOut === 3'b010, "R1 only register 1 loaded ones", int'(endOut), 2);

    done = 1'b1;
    report();
  end
endmodule